// File: doc/BRIEF.md
# Elastic Buffer Desynchronizer

The block takes one tributary's bit stream after overhead and stuffing bits have been removed. That stream is gapped and bursty, with a nominal average of 2.112 Mbit/s. The block turns it into an evenly spaced stream whose average rate matches the input, nominally 2.048 Mbit/s. Each accepted bit goes into a small first-in first-out store. A fractional clock enable, derived from a fast system clock, reads the store once per output bit period.

The division value of that enable is chosen again at every output bit. The store's fill level is compared with its half-full target. A fuller store selects one clock fewer per output bit, so reading speeds up. A store below target selects one clock more, so reading slows down. A store exactly at target keeps the nominal value. Over the long run, every bit written is read out, in order.

Reading waits until the store is half full. This applies after reset, after a resync request, and after the store runs dry at a read slot.

Top module: `desync_elastic`

## Requirements
- R1: After reset, out_en and out_bit are 0, the store is empty, and no out_en pulse appears while nothing is written.
- R2: A bit is stored on every clock with in_valid high while the store is not full, and bits leave in the order they were stored.
- R3: The store holds DEPTH bits (16). A bit offered while it already holds 16 is dropped and never appears at out_bit.
- R4: After reset, resync or an underflow, no out_en appears until the store holds DEPTH/2 (8) bits. The first pulse comes exactly DIV_NOM+2 clocks after the edge before the one that stores the eighth bit.
- R5: Each output bit is marked by a single-cycle out_en pulse, and out_bit then carries the oldest stored bit. out_bit does not change in cycles without out_en.
- R6: The gap between consecutive out_en pulses is chosen at the earlier pulse's read from the fill level before that read. The gap is DIV_NOM-1 clocks above 8, DIV_NOM at exactly 8, and DIV_NOM+1 below 8.
- R7: A read slot that finds the store empty produces no pulse and stops reading. Reading resumes only once 8 bits are held again.
- R8: A one-cycle resync discards all stored bits, including one offered in that cycle. No out_en follows in the next cycle, and reading waits for 8 new bits.
- R9: For a steady input at one bit every DIV_NOM-1 to DIV_NOM+1 clocks, every gap between pulses stays within DIV_NOM-1 to DIV_NOM+1 until the store drains. All written bits come out.

Default DIV_NOM is 24. With a 50 MHz clock that gives roughly 2.08 Mbit/s nominal, trimmed to about 2.17 and 2.0 Mbit/s.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_bit | input | 1 | Gapped tributary data bit |
| in_valid | input | 1 | Qualifies in_bit for one clock |
| resync | input | 1 | Flushes the store and re-arms the half-full wait |
| out_bit | output | 1 | Smoothed output data bit, held between pulses |
| out_en | output | 1 | One-clock enable marking each new out_bit |

## Verification
The hardest condition to reach from the ports is a precise fill level at each read slot. The rate-trim rule can only be seen as exact pulse spacing when the level at every slot is known. The bench gets there by writing sixteen bits back to back before the first read slot. It then writes nothing more, so the level falls by one at each slot from 16 down to 1. This forces every gap value in a known sequence and ends in an underflow. The overflow case and the two rate-limit streams are reached the same way: the exact number of writes and the write period are fixed in advance.

// File: rtl/desync_pkg.sv
`timescale 1ns/1ps
package desync_pkg;

  // Clocks per output bit, picked from the fill level seen at a read slot.
  function automatic int pick_div(input int fill, input int target, input int nominal);
    if (fill > target)      return nominal - 1;
    else if (fill < target) return nominal + 1;
    else                    return nominal;
  endfunction

  // Index step around a ring of 'size' entries.
  function automatic int ring_next(input int idx, input int size);
    return (idx == size - 1) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/desync_fifo.sv
`timescale 1ns/1ps
module desync_fifo #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       wr_req,
  input  logic                       wr_bit,
  input  logic                       rd_req,
  output logic                       rd_bit,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       full,
  output logic                       empty,
  output logic                       wr_accept
);
  import desync_pkg::*;

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] mem;
  logic [AW-1:0]    wptr, rptr;
  logic             do_rd;

  assign full      = (level == LW'(DEPTH));
  assign empty     = (level == '0);
  assign wr_accept = wr_req && !full && !flush;
  assign do_rd     = rd_req && !empty && !flush;
  assign rd_bit    = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_accept) mem[wptr] <= wr_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (wr_accept) wptr <= AW'(ring_next(int'(wptr), DEPTH));
      if (do_rd)     rptr <= AW'(ring_next(int'(rptr), DEPTH));
      case ({wr_accept, do_rd})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/desync_rate_ctl.sv
`timescale 1ns/1ps
module desync_rate_ctl #(
  parameter int DEPTH   = 16,
  parameter int DIV_NOM = 24
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic [$clog2(DEPTH+1)-1:0]   level,
  input  logic                         empty,
  output logic                         rd_go,
  output logic                         underflow,
  output logic                         primed,
  output logic [$clog2(DIV_NOM+2)-1:0] div_cur
);
  import desync_pkg::*;

  localparam int LW   = $clog2(DEPTH + 1);
  localparam int CW   = $clog2(DIV_NOM + 2);
  localparam int HALF = DEPTH / 2;

  logic [CW-1:0] cnt;
  logic          slot;

  // Read slot: last clock of the current output bit period.
  assign slot      = primed && (cnt == div_cur - CW'(1));
  assign rd_go     = slot && !empty && !flush;
  assign underflow = slot && empty && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      primed  <= 1'b0;
      cnt     <= '0;
      div_cur <= CW'(DIV_NOM);
    end else if (!primed) begin
      cnt     <= '0;
      div_cur <= CW'(DIV_NOM);
      if (level >= LW'(HALF)) primed <= 1'b1;
    end else if (slot) begin
      cnt     <= '0;
      div_cur <= CW'(pick_div(int'(level), HALF, DIV_NOM));
      if (empty) primed <= 1'b0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/desync_elastic.sv
`timescale 1ns/1ps
module desync_elastic #(
  parameter int DEPTH   = 16,
  parameter int DIV_NOM = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_bit,
  input  logic in_valid,
  input  logic resync,
  output logic out_bit,
  output logic out_en
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int CW = $clog2(DIV_NOM + 2);

  // Internal events, named for the checker.
  logic          fifo_full, fifo_empty, wr_ok;
  logic          rd_go, underflow, primed, rd_bit;
  logic [LW-1:0] fifo_level;
  logic [CW-1:0] div_cur;

  desync_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (resync),
    .wr_req    (in_valid),
    .wr_bit    (in_bit),
    .rd_req    (rd_go),
    .rd_bit    (rd_bit),
    .level     (fifo_level),
    .full      (fifo_full),
    .empty     (fifo_empty),
    .wr_accept (wr_ok)
  );

  desync_rate_ctl #(.DEPTH(DEPTH), .DIV_NOM(DIV_NOM)) u_rate (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (resync),
    .level     (fifo_level),
    .empty     (fifo_empty),
    .rd_go     (rd_go),
    .underflow (underflow),
    .primed    (primed),
    .div_cur   (div_cur)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_en  <= 1'b0;
      out_bit <= 1'b0;
    end else begin
      out_en <= rd_go;
      if (rd_go) out_bit <= rd_bit;
    end
  end

endmodule

// File: rtl/desync_elastic_chk.sv
`timescale 1ns/1ps
module desync_elastic_chk #(
  parameter int DEPTH   = 16,
  parameter int DIV_NOM = 24
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         resync,
  input logic                         wr_ok,
  input logic                         fifo_full,
  input logic [$clog2(DEPTH+1)-1:0]   fifo_level,
  input logic                         primed,
  input logic                         underflow,
  input logic [$clog2(DIV_NOM+2)-1:0] div_cur,
  input logic                         out_en,
  input logic                         out_bit
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int CW = $clog2(DIV_NOM + 2);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !wr_ok);

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH));

  assert_wait_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> $past(primed));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |=> !out_en);

  assert_hold_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> $stable(out_bit));

  assert_div_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (div_cur >= CW'(DIV_NOM - 1) && div_cur <= CW'(DIV_NOM + 1)));

  assert_underflow_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> !primed);

  assert_resync_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (!out_en && fifo_level == '0 && !primed));

endmodule

bind desync_elastic desync_elastic_chk #(.DEPTH(DEPTH), .DIV_NOM(DIV_NOM)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .resync     (resync),
  .wr_ok      (wr_ok),
  .fifo_full  (fifo_full),
  .fifo_level (fifo_level),
  .primed     (primed),
  .underflow  (underflow),
  .div_cur    (div_cur),
  .out_en     (out_en),
  .out_bit    (out_bit)
);

// File: tb/desync_elastic_tb.sv
`timescale 1ns/1ps
module desync_elastic_tb;
  localparam int DEPTH   = 16;
  localparam int DIV_NOM = 24;
  localparam int HALF    = DEPTH / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_bit = 1'b0;
  logic in_valid = 1'b0;
  logic resync = 1'b0;
  logic out_bit, out_en;

  desync_elastic #(.DEPTH(DEPTH), .DIV_NOM(DIV_NOM)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_bit(in_bit), .in_valid(in_valid),
    .resync(resync), .out_bit(out_bit), .out_en(out_en)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Expected stream, written by the tasks only.
  logic exp_bits [0:4095];
  int wri = 0;
  int serial = 0;
  int flush_req = 0;
  int iv_req = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Monitor state, written by the monitor only.
  int rdi = 0;
  int pulses = 0;
  int last_cyc = -1;
  int iv_min = 1000000;
  int iv_max = 0;
  int ivn = 0;
  int iv_log [0:63];
  int mon_checks = 0;
  int mon_errs = 0;
  int flush_seen = 0;
  int iv_seen = 0;

  always @(negedge clk) begin
    if (flush_seen != flush_req) begin
      flush_seen = flush_req;
      rdi = wri;
    end
    if (iv_seen != iv_req) begin
      iv_seen = iv_req;
      last_cyc = -1; iv_min = 1000000; iv_max = 0; ivn = 0;
    end
    if (rst_n && out_en) begin
      mon_checks++;
      if (rdi >= wri) begin
        mon_errs++;
        $display("FAIL R5 pulse with no stored bit: actual=%0d expected=%0d", rdi, wri - 1);
      end else begin
        if (out_bit !== exp_bits[rdi]) begin
          mon_errs++;
          $display("FAIL R2 order at bit %0d: actual=%0d expected=%0d", rdi, out_bit, exp_bits[rdi]);
        end
        rdi++;
      end
      pulses++;
      if (last_cyc >= 0) begin
        if (ivn < 64) iv_log[ivn] = cyc - last_cyc;
        if (cyc - last_cyc < iv_min) iv_min = cyc - last_cyc;
        if (cyc - last_cyc > iv_max) iv_max = cyc - last_cyc;
        ivn++;
      end
      last_cyc = cyc;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic pat(input int k);
    return logic'((((k * 5 + 1) / 3) ^ (k / 7)) & 1);
  endfunction

  task automatic burst(input int n, input int push_n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_bit = pat(serial); serial++;
      in_valid = 1'b1;
      if (i < push_n) begin exp_bits[wri] = in_bit; wri++; end
    end
    @(posedge clk); #1 in_valid = 1'b0;
  endtask

  task automatic stream(input int n, input int period);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_bit = pat(serial); serial++;
      in_valid = 1'b1;
      exp_bits[wri] = in_bit; wri++;
      @(posedge clk); #1 in_valid = 1'b0;
      repeat (period - 2) @(posedge clk);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 3000 && rdi != wri; i++) @(posedge clk);
    repeat (80) @(posedge clk);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R1 out_en after reset", out_en, 0);
    chk("R1 out_bit after reset", out_bit, 0);
    repeat (60) @(posedge clk);
    chk("R1 no pulse while idle", pulses, 0);
  endtask

  task automatic test_prime();
    int c0;
    burst(HALF - 1, HALF - 1);
    repeat (200) @(posedge clk);
    chk("R4 no pulse below half", pulses, 0);
    iv_req++;
    @(posedge clk); #1;
    c0 = cyc;
    in_bit = pat(serial); serial++; in_valid = 1'b1;
    exp_bits[wri] = in_bit; wri++;
    @(posedge clk); #1 in_valid = 1'b0;
    for (int i = 0; i < 200 && pulses == 0; i++) @(negedge clk);
    chk("R4 first pulse delay", last_cyc - c0, DIV_NOM + 2);
    drain();
    chk("R4 half-fill drained", pulses, HALF);
  endtask

  task automatic test_gap_sequence();
    int p0;
    p0 = pulses;
    iv_req++;
    burst(DEPTH, DEPTH);
    drain();
    chk("R6 pulses from full store", pulses - p0, DEPTH);
    for (int k = 0; k < DEPTH - 1; k++)
      chk($sformatf("R6 gap %0d", k), iv_log[k],
          (k < HALF) ? DIV_NOM - 1 : (k == HALF) ? DIV_NOM : DIV_NOM + 1);
  endtask

  task automatic test_underflow();
    int p0;
    p0 = pulses;
    repeat (100) @(posedge clk);
    chk("R7 stopped after empty slot", pulses - p0, 0);
    burst(HALF - 1, HALF - 1);
    repeat (100) @(posedge clk);
    chk("R7 waits for re-prime", pulses - p0, 0);
    burst(1, 1);
    drain();
    chk("R7 resumes after re-prime", pulses - p0, HALF);
  endtask

  task automatic test_overflow();
    int p0;
    p0 = pulses;
    burst(DEPTH + 4, DEPTH);
    drain();
    chk("R3 only DEPTH bits out", pulses - p0, DEPTH);
    chk("R3 all kept bits read", rdi, wri);
  endtask

  task automatic test_resync();
    int p0;
    p0 = pulses;
    burst(12, 12);
    for (int i = 0; i < 500 && pulses - p0 < 3; i++) @(negedge clk);
    @(posedge clk); #1;
    resync = 1'b1;
    in_bit = pat(serial); serial++; in_valid = 1'b1;
    @(posedge clk); #1;
    resync = 1'b0; in_valid = 1'b0;
    flush_req++;
    @(negedge clk);
    chk("R8 no pulse after resync", out_en, 0);
    p0 = pulses;
    repeat (100) @(posedge clk);
    chk("R8 flushed bits never appear", pulses - p0, 0);
    burst(HALF, HALF);
    drain();
    chk("R8 new bits after resync", pulses - p0, HALF);
  endtask

  task automatic test_stream(input int period);
    int p0;
    p0 = pulses;
    iv_req++;
    stream(300, period);
    drain();
    chk($sformatf("R9 count at period %0d", period), pulses - p0, 300);
    chk($sformatf("R9 min gap at period %0d", period), (iv_min >= DIV_NOM - 1) ? 1 : 0, 1);
    chk($sformatf("R9 max gap at period %0d", period), (iv_max <= DIV_NOM + 1) ? 1 : 0, 1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    test_reset();
    test_prime();
    test_gap_sequence();
    test_underflow();
    test_overflow();
    test_resync();
    test_stream(DIV_NOM - 1);
    test_stream(DIV_NOM + 1);
    repeat (5) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks, errors + mon_errs);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("FAIL watchdog expired: actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks + 1, errors + mon_errs + 1);
      $finish;
    end
  end

endmodule